// File: doc/BRIEF.md
# Operand Address Resolver

This block turns an instruction's addressing-mode code and operand field into the operand the execution stage needs. That operand is either a data word or an effective address. It reads three register values: an index register, a base register and the current program counter. It also owns a request/acknowledge read port to a word-addressed memory. Depending on the mode, it makes zero, one or two reads through that port.

A request is presented with `req_valid` while `busy` is low. The block then works through its sequence on its own. When it has finished, it raises `done` for one cycle. At the same moment `result` carries the resolved word and `result_is_addr` tells the consumer whether that word is an address or a value. An unknown mode code finishes at once with `illegal` raised. All additions wrap at the address width and report no overflow.

Top module: `opaddr_resolver`

## Requirements
- R1: Mode code 0 (immediate) returns the operand field zero-extended to the data width, with `result_is_addr` low. It makes no memory read, and `done` rises in the cycle after the request is accepted.
- R2: Mode code 1 (direct) makes exactly one read, at the zero-extended operand address. It returns the word read, with `result_is_addr` low.
- R3: Mode code 2 (indirect) makes exactly two reads. The first read is at the operand address. The second read is at the low address-width bits of the first word. The block returns the second word, with `result_is_addr` low.
- R4: Mode code 3 (indexed) forms the effective address as the operand plus the index register, modulo 2^AW. With `req_fetch` low, it returns that address with `result_is_addr` high and makes no read. With `req_fetch` high, it makes one read at that address and returns the data.
- R5: Mode code 4 (base) behaves like R4, except that the base register replaces the index register.
- R6: Mode code 5 (relative) returns the program counter plus the operand, sign-extended from its top bit, modulo 2^AW. It sets `result_is_addr` high, makes no read, and ignores `req_fetch`.
- R7: Mode codes 6 and 7 finish in the cycle after acceptance. They raise `illegal` together with `done`, return zero, and make no read.
- R8: `busy` is high from acceptance until `done`, and `mem_req` is never high while `busy` is low. A `req_valid` that arrives while `busy` is high is ignored: it changes neither the result nor the number of `done` pulses.
- R9: `done` lasts one cycle for each accepted request, and `busy` is low whenever `done` is high. Once `mem_req` is raised, it and `mem_addr` hold steady until `mem_ack` is seen.
- R10: After reset, `busy`, `done`, `illegal` and `mem_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_mode | input | 3 | Addressing-mode code |
| req_operand | input | OPW | Operand field of the instruction |
| req_fetch | input | 1 | Indexed/base: 1 returns data, 0 returns address |
| idx_reg | input | AW | Index register value |
| base_reg | input | AW | Base register value |
| pc | input | AW | Current program counter |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read word address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | DW | Resolved value or address |
| result_is_addr | output | 1 | High when `result` is an address |
| illegal | output | 1 | Unknown mode code, pulses with `done` |

## Verification
The assertions assume three things about the environment. The memory raises `mem_ack` only while `mem_req` is high. An acknowledge lasts one cycle. Register inputs stay steady in the cycle a request is accepted. The bench's memory model follows this: it answers each request after a chosen latency with a single-cycle acknowledge, and it drops the acknowledge before it looks at the next address. Requests are driven only on falling edges. The busy-overlap scenario withdraws its extra `req_valid` before the block can return to idle.

// File: rtl/oar_pkg.sv
package oar_pkg;
  localparam logic [2:0] MODE_IMM  = 3'd0;
  localparam logic [2:0] MODE_DIR  = 3'd1;
  localparam logic [2:0] MODE_IND  = 3'd2;
  localparam logic [2:0] MODE_IDX  = 3'd3;
  localparam logic [2:0] MODE_BASE = 3'd4;
  localparam logic [2:0] MODE_REL  = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2
  } oar_state_t;

  typedef struct packed {
    logic illegal;
    logic imm;
    logic rd1;
    logic rd2;
  } oar_plan_t;
endpackage

// File: rtl/oar_mode_decode.sv
module oar_mode_decode
  import oar_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       fetch,
  output oar_plan_t  plan
);
  always_comb begin
    plan = '0;
    case (mode)
      MODE_IMM:  plan.imm = 1'b1;
      MODE_DIR:  plan.rd1 = 1'b1;
      MODE_IND:  begin plan.rd1 = 1'b1; plan.rd2 = 1'b1; end
      MODE_IDX:  plan.rd1 = fetch;
      MODE_BASE: plan.rd1 = fetch;
      MODE_REL:  plan.rd1 = 1'b0;
      default:   plan.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/oar_ea_calc.sv
module oar_ea_calc
  import oar_pkg::*;
#(
  parameter int AW  = 16,
  parameter int OPW = 12
) (
  input  logic [2:0]     mode,
  input  logic [OPW-1:0] operand,
  input  logic [AW-1:0]  idx_reg,
  input  logic [AW-1:0]  base_reg,
  input  logic [AW-1:0]  pc,
  output logic [AW-1:0]  ea
);
  logic [AW-1:0] op_zext;
  logic [AW-1:0] op_sext;

  generate
    if (OPW < AW) begin : g_widen
      localparam int PAD = AW - OPW;
      assign op_zext = {{PAD{1'b0}}, operand};
      assign op_sext = {{PAD{operand[OPW-1]}}, operand};
    end else begin : g_narrow
      assign op_zext = operand[AW-1:0];
      assign op_sext = operand[AW-1:0];
    end
  endgenerate

  always_comb begin
    case (mode)
      MODE_IDX:  ea = op_zext + idx_reg;
      MODE_BASE: ea = op_zext + base_reg;
      MODE_REL:  ea = pc + op_sext;
      default:   ea = op_zext;
    endcase
  end
endmodule

// File: rtl/oar_seq.sv
module oar_seq
  import oar_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  oar_plan_t     plan,
  input  logic [AW-1:0] ea,
  input  logic [DW-1:0] imm_value,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          result_is_addr,
  output logic          illegal
);
  oar_state_t    state;
  logic          need_second;
  logic [AW-1:0] ptr_addr;

  assign busy     = (state != ST_IDLE);
  assign ptr_addr = AW'(mem_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      need_second    <= 1'b0;
      mem_req        <= 1'b0;
      mem_addr       <= '0;
      done           <= 1'b0;
      illegal        <= 1'b0;
      result         <= '0;
      result_is_addr <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (plan.illegal) begin
              done           <= 1'b1;
              illegal        <= 1'b1;
              result         <= '0;
              result_is_addr <= 1'b0;
            end else if (plan.rd1) begin
              state       <= ST_RD1;
              need_second <= plan.rd2;
              mem_req     <= 1'b1;
              mem_addr    <= ea;
            end else begin
              done           <= 1'b1;
              result         <= plan.imm ? imm_value : DW'(ea);
              result_is_addr <= !plan.imm;
            end
          end
        end
        ST_RD1: begin
          if (mem_ack) begin
            if (need_second) begin
              state    <= ST_RD2;
              mem_addr <= ptr_addr;
            end else begin
              state          <= ST_IDLE;
              mem_req        <= 1'b0;
              done           <= 1'b1;
              result         <= mem_rdata;
              result_is_addr <= 1'b0;
            end
          end
        end
        ST_RD2: begin
          if (mem_ack) begin
            state          <= ST_IDLE;
            mem_req        <= 1'b0;
            done           <= 1'b1;
            result         <= mem_rdata;
            result_is_addr <= 1'b0;
          end
        end
        default: begin
          state   <= ST_IDLE;
          mem_req <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/opaddr_resolver.sv
module opaddr_resolver
  import oar_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int OPW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [2:0]     req_mode,
  input  logic [OPW-1:0] req_operand,
  input  logic           req_fetch,
  input  logic [AW-1:0]  idx_reg,
  input  logic [AW-1:0]  base_reg,
  input  logic [AW-1:0]  pc,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  result,
  output logic           result_is_addr,
  output logic           illegal
);
  oar_plan_t     plan;
  logic [AW-1:0] ea;
  logic [DW-1:0] imm_value;
  logic          start;

  assign imm_value = DW'(req_operand);
  assign start     = req_valid && !busy;

  oar_mode_decode u_decode (
    .mode  (req_mode),
    .fetch (req_fetch),
    .plan  (plan)
  );

  oar_ea_calc #(.AW(AW), .OPW(OPW)) u_ea (
    .mode     (req_mode),
    .operand  (req_operand),
    .idx_reg  (idx_reg),
    .base_reg (base_reg),
    .pc       (pc),
    .ea       (ea)
  );

  oar_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .plan           (plan),
    .ea             (ea),
    .imm_value      (imm_value),
    .mem_ack        (mem_ack),
    .mem_rdata      (mem_rdata),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .busy           (busy),
    .done           (done),
    .result         (result),
    .result_is_addr (result_is_addr),
    .illegal        (illegal)
  );
endmodule

// File: rtl/oar_checker.sv
module oar_checker #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [2:0]    req_mode,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result,
  input logic          result_is_addr,
  input logic          illegal
);
  logic accept;
  assign accept = req_valid && !busy;

  a_r1_imm_next_cycle: assert property (@(posedge clk) disable iff (rst)
    accept && req_mode == 3'd0 |=> done && !result_is_addr && !mem_req);

  a_r6_rel_no_read: assert property (@(posedge clk) disable iff (rst)
    accept && req_mode == 3'd5 |=> done && result_is_addr && !mem_req);

  a_r7_illegal_code: assert property (@(posedge clk) disable iff (rst)
    accept && req_mode[2:1] == 2'b11 |=> done && illegal && result == '0 && !mem_req);

  a_r7_illegal_with_done: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);

  a_r8_idle_no_read: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

bind opaddr_resolver oar_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_mode       (req_mode),
  .mem_req        (mem_req),
  .mem_addr       (mem_addr),
  .mem_ack        (mem_ack),
  .busy           (busy),
  .done           (done),
  .result         (result),
  .result_is_addr (result_is_addr),
  .illegal        (illegal)
);

// File: tb/opaddr_resolver_bench.sv
module opaddr_resolver_bench;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int OPW = 12;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [2:0]     req_mode = '0;
  logic [OPW-1:0] req_operand = '0;
  logic           req_fetch = 1'b0;
  logic [AW-1:0]  idx_reg = '0;
  logic [AW-1:0]  base_reg = '0;
  logic [AW-1:0]  pc = '0;
  logic           mem_req;
  logic [AW-1:0]  mem_addr;
  logic           mem_ack = 1'b0;
  logic [DW-1:0]  mem_rdata = '0;
  logic           busy;
  logic           done;
  logic [DW-1:0]  result;
  logic           result_is_addr;
  logic           illegal;

  int checks = 0;
  int fails = 0;
  int ack_count = 0;
  int mem_lat = 0;
  int wcnt = 0;
  logic [DW-1:0] mem [256];

  logic [DW-1:0] got_result;
  logic          got_is_addr;
  logic          got_illegal;
  int            got_lat;
  int            got_reads;

  always #10 clk = ~clk;

  opaddr_resolver #(.AW(AW), .DW(DW), .OPW(OPW)) u_opaddr_resolver (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_operand(req_operand), .req_fetch(req_fetch), .idx_reg(idx_reg),
    .base_reg(base_reg), .pc(pc), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .result(result), .result_is_addr(result_is_addr), .illegal(illegal)
  );

  // memory responder: single-cycle ack after mem_lat waiting cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= mem_lat) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr[7:0]];
          ack_count++;
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] m, input logic [OPW-1:0] op, input logic f);
    int reads0;
    @(negedge clk);
    req_mode = m; req_operand = op; req_fetch = f; req_valid = 1'b1;
    reads0 = ack_count;
    @(negedge clk);
    req_valid = 1'b0;
    got_lat = 1;
    while (!done && got_lat < 500) begin
      @(negedge clk);
      got_lat++;
    end
    got_result = result;
    got_is_addr = result_is_addr;
    got_illegal = illegal;
    got_reads = ack_count - reads0;
    chk("R9 done seen", 32'(done), 32'd1);
    @(negedge clk);
    chk("R9 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 illegal", 32'(illegal), 0);
    chk("R10 mem_req", 32'(mem_req), 0);
    rst = 1'b0;
  endtask

  task automatic t_immediate();
    run_op(3'd0, 12'hABC, 1'b0);
    chk("R1 value", 32'(got_result), 32'h0ABC);
    chk("R1 flag", 32'(got_is_addr), 0);
    chk("R1 reads", got_reads, 0);
    chk("R1 latency", got_lat, 1);
    run_op(3'd0, 12'h000, 1'b1);
    chk("R1 zero value", 32'(got_result), 0);
  endtask

  task automatic t_direct();
    mem_lat = 0;
    run_op(3'd1, 12'h033, 1'b0);
    chk("R2 data", 32'(got_result), 32'(mem[8'h33]));
    chk("R2 reads", got_reads, 1);
    chk("R2 flag", 32'(got_is_addr), 0);
    mem_lat = 3;
    run_op(3'd1, 12'h07F, 1'b0);
    chk("R2 slow data", 32'(got_result), 32'(mem[8'h7F]));
  endtask

  task automatic t_indirect();
    mem_lat = 0;
    run_op(3'd2, 12'h010, 1'b0);
    chk("R3 data", 32'(got_result), 32'(mem[8'h40]));
    chk("R3 reads", got_reads, 2);
    mem_lat = 2;
    run_op(3'd2, 12'h020, 1'b0);
    chk("R3 wide pointer", 32'(got_result), 32'(mem[8'h80]));
    chk("R3 reads slow", got_reads, 2);
  endtask

  task automatic t_indexed();
    mem_lat = 1;
    idx_reg = 16'h0030;
    run_op(3'd3, 12'h005, 1'b0);
    chk("R4 address", 32'(got_result), 32'h0035);
    chk("R4 addr flag", 32'(got_is_addr), 1);
    chk("R4 no read", got_reads, 0);
    run_op(3'd3, 12'h005, 1'b1);
    chk("R4 fetched", 32'(got_result), 32'(mem[8'h35]));
    chk("R4 fetched flag", 32'(got_is_addr), 0);
    idx_reg = 16'hFFFF;
    run_op(3'd3, 12'h002, 1'b0);
    chk("R4 wrap", 32'(got_result), 32'h0001);
  endtask

  task automatic t_base();
    base_reg = 16'h1200;
    run_op(3'd4, 12'h0FF, 1'b0);
    chk("R5 address", 32'(got_result), 32'h12FF);
    chk("R5 no read", got_reads, 0);
    base_reg = 16'h0040;
    run_op(3'd4, 12'h011, 1'b1);
    chk("R5 fetched", 32'(got_result), 32'(mem[8'h51]));
    chk("R5 reads", got_reads, 1);
  endtask

  task automatic t_relative();
    pc = 16'h0100;
    run_op(3'd5, 12'hFF0, 1'b0);
    chk("R6 backward", 32'(got_result), 32'h00F0);
    chk("R6 flag", 32'(got_is_addr), 1);
    pc = 16'hFFF8;
    run_op(3'd5, 12'h010, 1'b1);
    chk("R6 wrap", 32'(got_result), 32'h0008);
    chk("R6 fetch ignored", got_reads, 0);
  endtask

  task automatic t_illegal();
    run_op(3'd6, 12'h123, 1'b1);
    chk("R7 flag 6", 32'(got_illegal), 1);
    chk("R7 result 6", 32'(got_result), 0);
    chk("R7 reads 6", got_reads, 0);
    run_op(3'd7, 12'h044, 1'b0);
    chk("R7 flag 7", 32'(got_illegal), 1);
    chk("R7 latency 7", got_lat, 1);
  endtask

  task automatic t_busy_ignore();
    int dones;
    mem_lat = 4;
    dones = 0;
    @(negedge clk);
    req_mode = 3'd1; req_operand = 12'h005; req_fetch = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk("R8 busy after accept", 32'(busy), 1);
    req_mode = 3'd0; req_operand = 12'h777;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (done) begin
        dones++;
        chk("R8 result kept", 32'(result), 32'(mem[8'h05]));
      end
      @(negedge clk);
    end
    chk("R8 single done", dones, 1);
    chk("R8 idle after", 32'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h5A00 + 16'(i * 3);
    mem[8'h10] = 16'h0040;
    mem[8'h20] = 16'hFF80;
    t_reset();
    t_immediate();
    t_direct();
    t_indirect();
    t_indexed();
    t_base();
    t_relative();
    t_illegal();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule